// File: doc/BRIEF.md
# Dual-Mode Block RAM with Output Pipeline

This block is a synchronous on-chip memory that can be set up in one of two shapes by a parameter. In two-port mode it holds 1024 lanes of 18 bits, where each lane is 16 data bits and 2 parity bits. Ports A and B each have their own enable, write enable, address and data buses, and each can read or write any location. In wide mode the same storage is seen as 512 words of 36 bits. The two port input buses are joined into one wide write port, and the two output buses are joined into one wide read port. The port A controls drive the read side and the port B enable drives the write side.

Each output lane has two stages. The first is a data latch, which captures the addressed contents on an enabled edge and can be loaded with a per-lane reset value. The second is an optional output register, which has its own clock enable and its own synchronous reset. A parameter chooses, for each port, whether that register reset overrides the clock enable or waits for it.

The memory has no valid/ready handshake. Both ports take a request on every edge on which their enable is high, so they never apply back-pressure. Read data is due a fixed number of edges later, and the consumer has no way to stall it. All ports share one clock.

Top module: `dual_mode_bram`

## Requirements
- R1: In two-port mode, an edge with a port's enable and write enable high stores {parity, data} at that port's address. An edge with the enable high and the write enable low loads that location into the port's latch. Without the output register, the value is on {pout, dout} after that edge. Either port can read what the other port wrote.
- R2: A write and a read on the same port, at the same address and on the same edge, are read-before-write: the latch captures the contents from before the write.
- R3: While a port's enable is low, that port writes nothing and its latch holds its value.
- R4: In wide mode, an edge with b_en high writes one 36-bit word at word index b_addr[9:1]. b_addr bit 0 is ignored. The word's data is {b_din, a_din} and its parity is {b_pin, a_pin}.
- R5: In wide mode, a_en is the read enable and the read word index is a_addr[9:1]. The low half of the word comes out on a_dout/a_pout and the high half on b_dout/b_pout.
- R6: A high latch-reset input loads the lane's reset value into the latch on the next edge, whatever the enable is. Port A uses reset value A and port B uses reset value B.
- R7: With the output register enabled, read data reaches the outputs two edges after the read edge, provided the register clock enable is high on the second edge. A latch reset also shows at the outputs one edge later than it would without the register.
- R8: While its clock enable is low, the output register holds, even though the latch underneath it changes.
- R9: With reset-first priority, a register reset loads the reset value on the next edge even when the clock enable is low.
- R10: With enable-first priority, a register reset with the clock enable low leaves the register unchanged. With the clock enable high, it loads the reset value.
- R11: In wide mode, b_ce, b_rst_latch, b_rst_reg, a_we and b_we have no effect. Both lanes use a_ce, a_rst_latch and a_rst_reg. The high lane resets to reset value B.
- R12: Without the output register, the register reset input has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| a_en | input | 1 | Port A enable; read enable in wide mode |
| a_we | input | 1 | Port A write enable (two-port mode only) |
| a_addr | input | 10 | Port A lane address; read address in wide mode |
| a_din | input | 16 | Port A write data; low half of the wide write word |
| a_pin | input | 2 | Port A write parity; wide parity bits 1:0 |
| a_ce | input | 1 | Port A output register clock enable |
| a_rst_latch | input | 1 | Port A latch reset |
| a_rst_reg | input | 1 | Port A output register reset |
| a_dout | output | 16 | Port A read data; low half of the wide read word |
| a_pout | output | 2 | Port A read parity; wide parity bits 1:0 |
| b_en | input | 1 | Port B enable; write enable in wide mode |
| b_we | input | 1 | Port B write enable (two-port mode only) |
| b_addr | input | 10 | Port B lane address; write address in wide mode |
| b_din | input | 16 | Port B write data; high half of the wide write word |
| b_pin | input | 2 | Port B write parity; wide parity bits 3:2 |
| b_ce | input | 1 | Port B output register clock enable (two-port mode only) |
| b_rst_latch | input | 1 | Port B latch reset (two-port mode only) |
| b_rst_reg | input | 1 | Port B output register reset (two-port mode only) |
| b_dout | output | 16 | Port B read data; high half of the wide read word |
| b_pout | output | 2 | Port B read parity; wide parity bits 3:2 |

## Verification
Without the output register, read data and latch resets are due one edge after the edge on which they are driven. With the register, they are due two edges later, and a register reset is due one edge later. The bench drives inputs at falling edges and reads the outputs at the next falling edge, so each check counts only the rising edges in between. Every latency check is arranged so that the value from one edge earlier is known and different from the expected value, and the check fails if the data arrives an edge early or an edge late. Before each check of a held or ignored input, the outputs are first set to a known non-reset value.

// File: rtl/bram_pkg.sv
package bram_pkg;

  // Storage shape selected at build time
  typedef enum logic {
    MODE_TWO_PORT = 1'b0,
    MODE_WIDE     = 1'b1
  } bram_mode_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/bram_route.sv
module bram_route
  import bram_pkg::*;
#(
  parameter bram_mode_e  MODE   = MODE_TWO_PORT,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 18
) (
  input  logic                          a_en_i,
  input  logic                          a_we_i,
  input  logic [ADDR_W-1:0]             a_addr_i,
  input  logic [LANE_W-1:0]             a_word_i,
  input  logic                          a_ce_i,
  input  logic                          a_rl_i,
  input  logic                          a_rr_i,
  input  logic                          b_en_i,
  input  logic                          b_we_i,
  input  logic [ADDR_W-1:0]             b_addr_i,
  input  logic [LANE_W-1:0]             b_word_i,
  input  logic                          b_ce_i,
  input  logic                          b_rl_i,
  input  logic                          b_rr_i,
  output logic [LANES-1:0]              wr_o,
  output logic [LANES-1:0][ADDR_W-1:0]  waddr_o,
  output logic [LANES-1:0][LANE_W-1:0]  wdat_o,
  output logic [LANES-1:0][ADDR_W-1:0]  raddr_o,
  output logic [LANES-1:0]              en_o,
  output logic [LANES-1:0]              ce_o,
  output logic [LANES-1:0]              rl_o,
  output logic [LANES-1:0]              rr_o
);

  localparam bit WIDE = (MODE == MODE_WIDE);

  always_comb begin
    wdat_o[0] = a_word_i;
    wdat_o[1] = b_word_i;
    if (WIDE) begin
      // one wide word = two adjacent lanes, low half at the even lane
      wr_o       = {2{b_en_i}};
      waddr_o[0] = {b_addr_i[ADDR_W-1:1], 1'b0};
      waddr_o[1] = {b_addr_i[ADDR_W-1:1], 1'b1};
      raddr_o[0] = {a_addr_i[ADDR_W-1:1], 1'b0};
      raddr_o[1] = {a_addr_i[ADDR_W-1:1], 1'b1};
      en_o       = {2{a_en_i}};
      ce_o       = {2{a_ce_i}};
      rl_o       = {2{a_rl_i}};
      rr_o       = {2{a_rr_i}};
    end else begin
      wr_o       = {b_en_i & b_we_i, a_en_i & a_we_i};
      waddr_o[0] = a_addr_i;
      waddr_o[1] = b_addr_i;
      raddr_o[0] = a_addr_i;
      raddr_o[1] = b_addr_i;
      en_o       = {b_en_i, a_en_i};
      ce_o       = {b_ce_i, a_ce_i};
      rl_o       = {b_rl_i, a_rl_i};
      rr_o       = {b_rr_i, a_rr_i};
    end
  end

endmodule

// File: rtl/bram_store.sv
module bram_store
  import bram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 18
) (
  input  logic                          clk,
  input  logic [LANES-1:0]              wr_i,
  input  logic [LANES-1:0][ADDR_W-1:0]  waddr_i,
  input  logic [LANES-1:0][LANE_W-1:0]  wdat_i,
  input  logic [LANES-1:0][ADDR_W-1:0]  raddr_i,
  output logic [LANES-1:0][LANE_W-1:0]  rdat_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  // Both write ports land in one process; a same-address collision is unspecified
  always_ff @(posedge clk) begin
    for (int p = 0; p < LANES; p++) begin
      if (wr_i[p]) mem_q[waddr_i[p]] <= wdat_i[p];
    end
  end

  // Contents seen at an edge are the pre-write contents (read-before-write)
  always_comb begin
    for (int p = 0; p < LANES; p++) rdat_o[p] = mem_q[raddr_i[p]];
  end

  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed_q)
    (wr_i[0] && !(wr_i[1] && waddr_i[1] == waddr_i[0]))
      |=> mem_q[$past(waddr_i[0])] == $past(wdat_i[0])); // R1

endmodule

// File: rtl/bram_outpipe.sv
module bram_outpipe #(
  parameter int unsigned        LANE_W    = 18,
  parameter bit                 OUT_REG   = 1'b0,
  parameter bit                 RST_FIRST = 1'b1,
  parameter logic [LANE_W-1:0]  SRVAL     = '0
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic              rst_latch_i,
  input  logic              ce_i,
  input  logic              rst_reg_i,
  input  logic [LANE_W-1:0] raw_i,
  output logic [LANE_W-1:0] dout_o
);

  logic [LANE_W-1:0] latch_q;
  logic [LANE_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst_latch_i)  latch_q <= SRVAL;
    else if (en_i)    latch_q <= raw_i;
  end

  always_ff @(posedge clk) begin
    if (RST_FIRST) begin
      if (rst_reg_i)  reg_q <= SRVAL;
      else if (ce_i)  reg_q <= latch_q;
    end else if (ce_i) begin
      reg_q <= rst_reg_i ? SRVAL : latch_q;
    end
  end

  assign dout_o = OUT_REG ? reg_q : latch_q;

  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  AST_LATCH_RESET: assert property (@(posedge clk) disable iff (!armed_q)
    rst_latch_i |=> latch_q == SRVAL); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
    (!en_i && !rst_latch_i) |=> $stable(latch_q)); // R3
  AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (!armed_q)
    (ce_i && !rst_reg_i) |=> reg_q == $past(latch_q)); // R7
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
    (!ce_i && !rst_reg_i) |=> $stable(reg_q)); // R8
  AST_REG_RESET: assert property (@(posedge clk) disable iff (!armed_q)
    (rst_reg_i && (RST_FIRST || ce_i)) |=> reg_q == SRVAL); // R9
  AST_GATED_RESET_WAITS: assert property (@(posedge clk) disable iff (!armed_q)
    (!RST_FIRST && rst_reg_i && !ce_i) |=> $stable(reg_q)); // R10
  AST_NO_REG_PATH: assert property (@(posedge clk) disable iff (!armed_q)
    (!OUT_REG && rst_reg_i && !rst_latch_i && !en_i) |=> $stable(dout_o)); // R12

endmodule

// File: rtl/dual_mode_bram.sv
module dual_mode_bram
  import bram_pkg::*;
#(
  parameter bram_mode_e  MODE        = MODE_TWO_PORT,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PAR_W       = 2,
  parameter int unsigned ADDR_W      = 10,
  parameter bit          OUT_REG_A   = 1'b0,
  parameter bit          OUT_REG_B   = 1'b0,
  parameter bit          RST_FIRST_A = 1'b1,
  parameter bit          RST_FIRST_B = 1'b1,
  parameter logic [DATA_W+PAR_W-1:0] SRVAL_A = '0,
  parameter logic [DATA_W+PAR_W-1:0] SRVAL_B = '0
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  input  logic [PAR_W-1:0]  a_pin,
  input  logic              a_ce,
  input  logic              a_rst_latch,
  input  logic              a_rst_reg,
  output logic [DATA_W-1:0] a_dout,
  output logic [PAR_W-1:0]  a_pout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  input  logic [PAR_W-1:0]  b_pin,
  input  logic              b_ce,
  input  logic              b_rst_latch,
  input  logic              b_rst_reg,
  output logic [DATA_W-1:0] b_dout,
  output logic [PAR_W-1:0]  b_pout
);

  localparam int unsigned LANE_W = DATA_W + PAR_W;
  localparam bit          WIDE   = (MODE == MODE_WIDE);

  logic [LANES-1:0]              wr;
  logic [LANES-1:0][ADDR_W-1:0]  waddr;
  logic [LANES-1:0][LANE_W-1:0]  wdat;
  logic [LANES-1:0][ADDR_W-1:0]  raddr;
  logic [LANES-1:0][LANE_W-1:0]  rdat;
  logic [LANES-1:0]              lane_en, lane_ce, lane_rl, lane_rr;
  logic [LANES-1:0][LANE_W-1:0]  lane_out;

  bram_route #(.MODE(MODE), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_route (
    .a_en_i   (a_en),
    .a_we_i   (a_we),
    .a_addr_i (a_addr),
    .a_word_i ({a_pin, a_din}),
    .a_ce_i   (a_ce),
    .a_rl_i   (a_rst_latch),
    .a_rr_i   (a_rst_reg),
    .b_en_i   (b_en),
    .b_we_i   (b_we),
    .b_addr_i (b_addr),
    .b_word_i ({b_pin, b_din}),
    .b_ce_i   (b_ce),
    .b_rl_i   (b_rst_latch),
    .b_rr_i   (b_rst_reg),
    .wr_o     (wr),
    .waddr_o  (waddr),
    .wdat_o   (wdat),
    .raddr_o  (raddr),
    .en_o     (lane_en),
    .ce_o     (lane_ce),
    .rl_o     (lane_rl),
    .rr_o     (lane_rr)
  );

  bram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .wr_i    (wr),
    .waddr_i (waddr),
    .wdat_i  (wdat),
    .raddr_i (raddr),
    .rdat_o  (rdat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // wide mode runs the high lane with port A's pipeline options
    localparam bit OREG   = (l == 0 || WIDE) ? OUT_REG_A   : OUT_REG_B;
    localparam bit RFIRST = (l == 0 || WIDE) ? RST_FIRST_A : RST_FIRST_B;
    localparam logic [LANE_W-1:0] SV = (l == 0) ? SRVAL_A : SRVAL_B;

    bram_outpipe #(.LANE_W(LANE_W), .OUT_REG(OREG), .RST_FIRST(RFIRST), .SRVAL(SV)) u_pipe (
      .clk         (clk),
      .en_i        (lane_en[l]),
      .rst_latch_i (lane_rl[l]),
      .ce_i        (lane_ce[l]),
      .rst_reg_i   (lane_rr[l]),
      .raw_i       (rdat[l]),
      .dout_o      (lane_out[l])
    );
  end

  assign a_dout = lane_out[0][DATA_W-1:0];
  assign a_pout = lane_out[0][LANE_W-1:DATA_W];
  assign b_dout = lane_out[1][DATA_W-1:0];
  assign b_pout = lane_out[1][LANE_W-1:DATA_W];

endmodule

// File: tb/test_dual_mode_bram.sv
module test_dual_mode_bram;
  import bram_pkg::*;

  localparam logic [17:0] SV_A = 18'h1_2345;
  localparam logic [17:0] SV_B = 18'h2_6789;

  // {address, 18-bit lane word}
  localparam logic [27:0] VEC [8] = '{
    {10'h000, 18'h0_0001}, {10'h3FF, 18'h3_FFFF},
    {10'h155, 18'h2_AAAA}, {10'h2AA, 18'h1_5555},
    {10'h010, 18'h0_BEEF}, {10'h011, 18'h3_0F0F},
    {10'h200, 18'h1_8001}, {10'h0FF, 18'h2_1234}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        a_en, a_we, a_ce, a_rl, a_rr, b_en, b_we, b_ce, b_rl, b_rr;
  logic [9:0]  a_addr, b_addr;
  logic [15:0] a_din, b_din;
  logic [1:0]  a_pin, b_pin;
  logic [15:0] d0_ad, d0_bd, d1_ad, d1_bd, d2_ad, d2_bd;
  logic [1:0]  d0_ap, d0_bp, d1_ap, d1_bp, d2_ap, d2_bp;

  int checks = 0;
  int errors = 0;

  dual_mode_bram #(.MODE(MODE_TWO_PORT), .SRVAL_A(SV_A), .SRVAL_B(SV_B)) i_dual_mode_bram (
    .clk(clk), .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_ce(a_ce), .a_rst_latch(a_rl), .a_rst_reg(a_rr), .a_dout(d0_ad), .a_pout(d0_ap),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_ce(b_ce), .b_rst_latch(b_rl), .b_rst_reg(b_rr), .b_dout(d0_bd), .b_pout(d0_bp));

  dual_mode_bram #(.MODE(MODE_TWO_PORT), .OUT_REG_A(1'b1), .OUT_REG_B(1'b1),
    .RST_FIRST_A(1'b1), .RST_FIRST_B(1'b0), .SRVAL_A(SV_A), .SRVAL_B(SV_B)) i_dual_mode_bram_reg (
    .clk(clk), .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_ce(a_ce), .a_rst_latch(a_rl), .a_rst_reg(a_rr), .a_dout(d1_ad), .a_pout(d1_ap),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_ce(b_ce), .b_rst_latch(b_rl), .b_rst_reg(b_rr), .b_dout(d1_bd), .b_pout(d1_bp));

  dual_mode_bram #(.MODE(MODE_WIDE), .OUT_REG_A(1'b1), .OUT_REG_B(1'b0),
    .RST_FIRST_A(1'b1), .RST_FIRST_B(1'b0), .SRVAL_A(SV_A), .SRVAL_B(SV_B)) i_dual_mode_bram_sdp (
    .clk(clk), .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_ce(a_ce), .a_rst_latch(a_rl), .a_rst_reg(a_rr), .a_dout(d2_ad), .a_pout(d2_ap),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_ce(b_ce), .b_rst_latch(b_rl), .b_rst_reg(b_rr), .b_dout(d2_bd), .b_pout(d2_bp));

  task automatic idle();
    a_en = 0; a_we = 0; a_ce = 0; a_rl = 0; a_rr = 0;
    b_en = 0; b_we = 0; b_ce = 0; b_rl = 0; b_rr = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    a_addr = '0; b_addr = '0; a_din = '0; b_din = '0; a_pin = '0; b_pin = '0;
    // reset state: R6 latch reset, R9 register reset in every build
    a_rl = 1; a_rr = 1; a_ce = 1; b_rl = 1; b_rr = 1; b_ce = 1;
    step(); step();
    chk("R6 reset A lat",  {d0_ap, d0_ad}, SV_A);
    chk("R6 reset B lat",  {d0_bp, d0_bd}, SV_B);
    chk("R9 reset A reg",  {d1_ap, d1_ad}, SV_A);
    chk("R10 reset B reg", {d1_bp, d1_bd}, SV_B);
    chk("R11 reset wide lo", {d2_ap, d2_ad}, SV_A);
    chk("R11 reset wide hi", {d2_bp, d2_bd}, SV_B);
    idle();

    // R1 table: write on one port, read it back on the other
    for (int i = 0; i < 8; i++) begin
      logic [9:0]  ad;
      logic [17:0] w;
      ad = VEC[i][27:18];
      w  = VEC[i][17:0];
      idle();
      if (i % 2 == 0) begin a_en = 1; a_we = 1; a_addr = ad; {a_pin, a_din} = w; end
      else            begin b_en = 1; b_we = 1; b_addr = ad; {b_pin, b_din} = w; end
      step();
      idle();
      if (i % 2 == 0) begin b_en = 1; b_addr = ad; end
      else            begin a_en = 1; a_addr = ad; end
      step();
      if (i % 2 == 0) chk("R1 cross read B", {d0_bp, d0_bd}, w);
      else            chk("R1 cross read A", {d0_ap, d0_ad}, w);
    end

    // R2 read-before-write
    idle(); a_en = 1; a_we = 1; a_addr = 10'd5; {a_pin, a_din} = 18'h0_1111; step();
    {a_pin, a_din} = 18'h3_2222; step();
    chk("R2 old data on same-edge write", {d0_ap, d0_ad}, 18'h0_1111);
    a_we = 0; step();
    chk("R2 new data next read", {d0_ap, d0_ad}, 18'h3_2222);

    // R3 enable low: no write, latch holds
    a_en = 0; a_we = 1; {a_pin, a_din} = 18'h1_3333; step();
    chk("R3 latch holds", {d0_ap, d0_ad}, 18'h3_2222);
    a_en = 1; a_we = 0; step();
    chk("R3 no write while disabled", {d0_ap, d0_ad}, 18'h3_2222);

    // R6 latch reset regardless of enable
    idle(); a_rl = 1; b_rl = 1; b_en = 1; b_addr = 10'd5; step();
    chk("R6 latch reset A", {d0_ap, d0_ad}, SV_A);
    chk("R6 latch reset B with en", {d0_bp, d0_bd}, SV_B);

    // R12 register reset ignored without output register
    idle(); a_en = 1; a_addr = 10'd5; step();
    idle(); a_rr = 1; a_ce = 1; step();
    chk("R12 reg reset no effect", {d0_ap, d0_ad}, 18'h3_2222);

    // R7 two-edge latency with output register
    idle(); b_en = 1; b_we = 1; b_addr = 10'd9; {b_pin, b_din} = 18'h2_0F0F; a_rl = 1; step();
    idle(); a_en = 1; a_addr = 10'd9; a_ce = 1; step();
    chk("R7 not yet at one edge", {d1_ap, d1_ad}, SV_A);
    idle(); a_ce = 1; step();
    chk("R7 data at two edges", {d1_ap, d1_ad}, 18'h2_0F0F);
    idle(); a_rl = 1; a_ce = 1; step();
    chk("R7 latch reset delayed", {d1_ap, d1_ad}, 18'h2_0F0F);
    idle(); a_ce = 1; step();
    chk("R7 latch reset arrives", {d1_ap, d1_ad}, SV_A);

    // R8 clock enable low holds the register
    idle(); b_en = 1; b_we = 1; b_addr = 10'd10; {b_pin, b_din} = 18'h1_ABCD; step();
    idle(); a_en = 1; a_addr = 10'd10; step();
    idle(); step();
    chk("R8 hold with ce low", {d1_ap, d1_ad}, SV_A);
    a_ce = 1; step();
    chk("R8 loads when ce high", {d1_ap, d1_ad}, 18'h1_ABCD);

    // R9 reset-first priority on port A
    idle(); a_rr = 1; step();
    chk("R9 reset with ce low", {d1_ap, d1_ad}, SV_A);

    // R10 enable-first priority on port B
    idle(); b_en = 1; b_addr = 10'd10; b_ce = 1; step();
    idle(); b_ce = 1; step();
    chk("R10 B loaded", {d1_bp, d1_bd}, 18'h1_ABCD);
    idle(); b_rr = 1; step();
    chk("R10 reset waits for ce", {d1_bp, d1_bd}, 18'h1_ABCD);
    b_ce = 1; step();
    chk("R10 reset with ce", {d1_bp, d1_bd}, SV_B);

    // R4/R5 wide write and read, address bit 0 ignored
    idle(); b_en = 1; b_addr = 10'h007;
    a_din = 16'h1111; a_pin = 2'b01; b_din = 16'h2222; b_pin = 2'b10; step();
    idle(); a_en = 1; a_we = 1; a_addr = 10'h006; a_ce = 1;
    a_din = 16'hDEAD; a_pin = 2'b11; step();
    idle(); a_ce = 1; step();
    chk("R5 wide low half", {d2_ap, d2_ad}, 18'h1_1111);
    chk("R4 wide high half", {d2_bp, d2_bd}, 18'h2_2222);

    // R11 port B controls ignored in wide mode
    idle(); b_ce = 1; b_rl = 1; b_rr = 1; step();
    chk("R11 b controls ignored lo", {d2_ap, d2_ad}, 18'h1_1111);
    chk("R11 b controls ignored hi", {d2_bp, d2_bd}, 18'h2_2222);
    idle(); a_rr = 1; step();
    chk("R11 a reset lo", {d2_ap, d2_ad}, SV_A);
    chk("R11 a reset hi uses B value", {d2_bp, d2_bd}, SV_B);
    idle(); a_ce = 1; step();
    chk("R11 latch untouched by b reset", {d2_bp, d2_bd}, 18'h2_2222);
    idle(); a_en = 1; a_addr = 10'h006; a_ce = 1; step();
    idle(); a_ce = 1; step();
    chk("R11 a_we ignored in wide mode", {d2_ap, d2_ad}, 18'h1_1111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule